// File: doc/BRIEF.md
# Cartridge Address Decoder and Banking

This block is the glue logic of a game-console cartridge that carries a boot flash, a program RAM, a character RAM and a network controller with a memory-mapped bus. It watches the CPU address bus, the low data bits, the read/write line, the M2 phase clock and the active-low ROM-select strobe. From these it decodes an internal window at $6000-$7FFF. It keeps a 4-bit program bank and a 4-bit character bank. It drives the device selects and the upper address lines of the parallel memories.

The lower half of the window, $6xxx, is the banking port. A read there latches the low four address bits as the program bank, so software can switch banks with a plain load instruction. A write there latches the low four data bits as the character bank. The upper half, $7xxx, reaches the network controller through separate active-low read and write strobes. The controller has no chip enable. Both strobes are qualified by M2, so they fall only after the address has settled.

All logic runs from a fast system clock that oversamples M2. A bank register changes only at the falling edge of M2 that ends the access which loads it.

Top module: `cartDecoder`

## Requirements
- R1: `winSelN` is low exactly when M2 is high, `romSelN` is high, and address bits 14 and 13 are both 1.
- R2: Inside the window, address bit 12 picks the half (0 = $6xxx, 1 = $7xxx) and `rnw` picks the direction (1 = read). Exactly one of `bankRdN`, `bankWrN`, `netRdN`, `netWrN` is then low. Outside the window all four are high.
- R3: A read in $6xxx loads address bits 3..0 into the program bank.
- R4: A write in $6xxx loads data bits 3..0 into the character bank.
- R5: An active-low `rstN` clears both banks to 0, which selects slice 0 of the boot flash and slice 0 of character RAM.
- R6: While `romSelN` is low, `flashCeN` is low when program bank bit 3 is 0, and `prgRamCeN` is low when it is 1. Never are both low. Both are high while `romSelN` is high.
- R7: `prgAddrHi` carries program bank bits 1..0, which pick a 32 KiB slice. `chrAddrHi` carries the character bank, which picks an 8 KiB slice.
- R8: $7xxx accesses drive only `netRdN` or `netWrN`, and only while M2 is high. They leave both banks unchanged.
- R9: A bank output keeps its old value for as long as M2 stays high. The new value appears within two system clocks after M2 falls.
- R10: Program bank values 4 to 11 are latched like any other value. Only bit 3 picks the device, and bits 1..0 still form the slice.
- R11: A $6xxx address loads nothing when M2 never rises, when `romSelN` is low, or when address bit 13 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples M2 |
| rstN | input | 1 | Active-low hardware reset |
| m2 | input | 1 | CPU phase clock |
| romSelN | input | 1 | Active-low CPU select for $8000-$FFFF |
| rnw | input | 1 | CPU read (1) / write (0) |
| addr | input | 15 | CPU address bits 14..0 |
| data | input | 8 | CPU data bus |
| winSelN | output | 1 | Active-low $6000-$7FFF window select |
| bankRdN | output | 1 | Active-low read strobe for $6xxx |
| bankWrN | output | 1 | Active-low write strobe for $6xxx |
| netRdN | output | 1 | Active-low network controller read strobe ($7xxx) |
| netWrN | output | 1 | Active-low network controller write strobe ($7xxx) |
| flashCeN | output | 1 | Active-low boot flash select |
| prgRamCeN | output | 1 | Active-low program RAM select |
| prgAddrHi | output | 2 | Program slice address bits above CPU A14 |
| chrAddrHi | output | 4 | Character RAM slice address bits |

## Verification
A wrong program bank shows at the next ROM-select access. It either selects the wrong device through `flashCeN`/`prgRamCeN` or puts a wrong slice on `prgAddrHi`. A wrong character bank shows on `chrAddrHi` at once. Because banks change only at the fall of M2, a register that loads early, or that a $7xxx or unqualified access disturbs, shows within two system clocks of that M2 edge. The bench therefore checks the bank outputs both in the middle of each access and right after it ends. A wrong decode shows in the same cycle on the four strobes and the window select.

// File: rtl/cartPkg.sv
package cartPkg;
  // Decoded access strobes, active high; index = {half, isRead}
  typedef struct packed {
    logic       win;
    logic [3:0] acc;   // 0: write $6, 1: read $6, 2: write $7, 3: read $7
  } accStrb_t;

  localparam int ACC_WR_LO = 0;
  localparam int ACC_RD_LO = 1;
  localparam int ACC_WR_HI = 2;
  localparam int ACC_RD_HI = 3;
endpackage

// File: rtl/cartControl.sv
module cartControl
  import cartPkg::*;
(
  input  logic     m2,
  input  logic     romSelN,
  input  logic     rnw,
  input  logic [2:0] addrTop,   // CPU A14..A12
  output accStrb_t strb
);
  logic winHit;

  assign winHit   = m2 && romSelN && addrTop[2] && addrTop[1];
  assign strb.win = winHit;

  for (genvar i = 0; i < 4; i++) begin : g_acc
    localparam bit HALF = (i / 2) == 1;
    localparam bit RD   = (i % 2) == 1;
    assign strb.acc[i] = winHit && (addrTop[0] == HALF) && (rnw == RD);
  end
endmodule

// File: rtl/cartDatapath.sv
module cartDatapath
  import cartPkg::*;
#(
  parameter int BANK_W  = 4,
  parameter int SLICE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              m2,
  input  logic              romSelN,
  input  accStrb_t          strb,
  input  logic [BANK_W-1:0] addrLo,
  input  logic [BANK_W-1:0] dataLo,
  output logic              flashCeN,
  output logic              prgRamCeN,
  output logic [SLICE_W-1:0] prgAddrHi,
  output logic [BANK_W-1:0] chrAddrHi
);
  localparam int DEV_BIT = BANK_W - 1;

  logic              m2Prev;
  logic              m2Fall;
  logic              capRd;
  logic              capWr;
  logic [BANK_W-1:0] capAddr;
  logic [BANK_W-1:0] capData;
  logic [BANK_W-1:0] prgBank;
  logic [BANK_W-1:0] chrBank;

  assign m2Fall = m2Prev && !m2;

  // Capture the access while M2 is high; the last capture is used at the fall.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m2Prev  <= 1'b0;
      capRd   <= 1'b0;
      capWr   <= 1'b0;
      capAddr <= '0;
      capData <= '0;
    end else begin
      m2Prev <= m2;
      if (m2) begin
        capRd   <= strb.acc[ACC_RD_LO];
        capWr   <= strb.acc[ACC_WR_LO];
        capAddr <= addrLo;
        capData <= dataLo;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prgBank <= '0;
      chrBank <= '0;
    end else if (m2Fall) begin
      if (capRd) prgBank <= capAddr;
      if (capWr) chrBank <= capData;
    end
  end

  assign flashCeN  = !(!romSelN && !prgBank[DEV_BIT]);
  assign prgRamCeN = !(!romSelN &&  prgBank[DEV_BIT]);
  assign prgAddrHi = prgBank[SLICE_W-1:0];
  assign chrAddrHi = chrBank;
endmodule

// File: rtl/cartDecoder.sv
module cartDecoder
  import cartPkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 4,
  parameter int SLICE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               m2,
  input  logic               romSelN,
  input  logic               rnw,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  output logic               winSelN,
  output logic               bankRdN,
  output logic               bankWrN,
  output logic               netRdN,
  output logic               netWrN,
  output logic               flashCeN,
  output logic               prgRamCeN,
  output logic [SLICE_W-1:0] prgAddrHi,
  output logic [BANK_W-1:0]  chrAddrHi
);
  localparam int TOP_LSB = ADDR_W - 3;

  accStrb_t strb;
  logic     unusedBits;

  assign unusedBits = ^{addr[TOP_LSB-1:BANK_W], data[DATA_W-1:BANK_W]};

  cartControl u_ctrl (
    .m2      (m2),
    .romSelN (romSelN),
    .rnw     (rnw),
    .addrTop (addr[ADDR_W-1:TOP_LSB]),
    .strb    (strb)
  );

  cartDatapath #(.BANK_W(BANK_W), .SLICE_W(SLICE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .m2        (m2),
    .romSelN   (romSelN),
    .strb      (strb),
    .addrLo    (addr[BANK_W-1:0]),
    .dataLo    (data[BANK_W-1:0]),
    .flashCeN  (flashCeN),
    .prgRamCeN (prgRamCeN),
    .prgAddrHi (prgAddrHi),
    .chrAddrHi (chrAddrHi)
  );

  assign winSelN = !strb.win;
  assign bankRdN = !strb.acc[ACC_RD_LO];
  assign bankWrN = !strb.acc[ACC_WR_LO];
  assign netRdN  = !strb.acc[ACC_RD_HI];
  assign netWrN  = !strb.acc[ACC_WR_HI];
endmodule

// File: rtl/cartDecoderChecker.sv
module cartDecoderChecker #(
  parameter int SLICE_W = 2,
  parameter int BANK_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               m2,
  input logic               romSelN,
  input logic [14:0]        addr,
  input logic               winSelN,
  input logic               bankRdN,
  input logic               bankWrN,
  input logic               netRdN,
  input logic               netWrN,
  input logic               flashCeN,
  input logic               prgRamCeN,
  input logic [SLICE_W-1:0] prgAddrHi,
  input logic [BANK_W-1:0]  chrAddrHi
);
  p_win_m2_r1: assert property (@(posedge clk) disable iff (!rstN)
    !winSelN |-> (m2 && romSelN));

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!bankRdN, !bankWrN, !netRdN, !netWrN}) <= 1);

  p_strobe_in_win_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!bankRdN || !bankWrN || !netRdN || !netWrN) |-> !winSelN);

  p_dev_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashCeN && !prgRamCeN));

  p_dev_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    romSelN |-> (flashCeN && prgRamCeN));

  p_net_qual_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!netRdN || !netWrN) |-> (m2 && addr[12]));

  p_hold_m2_r9: assert property (@(posedge clk) disable iff (!rstN)
    (m2 && $past(m2)) |-> ($stable(prgAddrHi) && $stable(chrAddrHi)));
endmodule

bind cartDecoder cartDecoderChecker #(.SLICE_W(SLICE_W), .BANK_W(BANK_W)) i_chk (
  .clk(clk), .rstN(rstN), .m2(m2), .romSelN(romSelN), .addr(addr),
  .winSelN(winSelN), .bankRdN(bankRdN), .bankWrN(bankWrN),
  .netRdN(netRdN), .netWrN(netWrN), .flashCeN(flashCeN),
  .prgRamCeN(prgRamCeN), .prgAddrHi(prgAddrHi), .chrAddrHi(chrAddrHi)
);

// File: tb/test_cartDecoder.sv
`timescale 1ns/1ps
module test_cartDecoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        m2 = 1'b0;
  logic        romSelN = 1'b1;
  logic        rnw = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  data = '0;
  logic        winSelN, bankRdN, bankWrN, netRdN, netWrN, flashCeN, prgRamCeN;
  logic [1:0]  prgAddrHi;
  logic [3:0]  chrAddrHi;

  always #10 clk = ~clk;   // 50 MHz

  cartDecoder i_cartDecoder (
    .clk(clk), .rstN(rstN), .m2(m2), .romSelN(romSelN), .rnw(rnw),
    .addr(addr), .data(data), .winSelN(winSelN), .bankRdN(bankRdN),
    .bankWrN(bankWrN), .netRdN(netRdN), .netWrN(netWrN),
    .flashCeN(flashCeN), .prgRamCeN(prgRamCeN),
    .prgAddrHi(prgAddrHi), .chrAddrHi(chrAddrHi)
  );

  typedef enum int {K_SEL, K_BRD, K_BWR, K_NRD, K_NWR, K_PRG, K_CHR, K_FL, K_RAM} kind_t;
  typedef struct { kind_t kind; logic [3:0] exp; string req; } item_t;

  item_t q[$];
  event  evCheck;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  logic [3:0] mPrg = 4'h0;
  logic [3:0] mChr = 4'h0;

  function automatic logic [3:0] observe(kind_t k);
    case (k)
      K_SEL:   return {3'b0, winSelN};
      K_BRD:   return {3'b0, bankRdN};
      K_BWR:   return {3'b0, bankWrN};
      K_NRD:   return {3'b0, netRdN};
      K_NWR:   return {3'b0, netWrN};
      K_PRG:   return {2'b0, prgAddrHi};
      K_CHR:   return chrAddrHi;
      K_FL:    return {3'b0, flashCeN};
      default: return {3'b0, prgRamCeN};
    endcase
  endfunction

  // Monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(evCheck);
      while (q.size() > 0) begin
        item_t it;
        logic [3:0] act;
        it  = q.pop_front();
        act = observe(it.kind);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%s actual=%h expected=%h", it.req, it.kind.name(), act, it.exp);
        end
      end
    end
  end

  task automatic push(kind_t k, logic [3:0] e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic flush();
    #1;
    ->evCheck;
    #1;
  endtask

  task automatic expectBanks(string r);
    push(K_PRG, {2'b0, mPrg[1:0]}, r);
    push(K_CHR, mChr, r);
    flush();
  endtask

  // One CPU cycle; m2Rise=0 keeps M2 low throughout
  task automatic cpuAccess(logic [14:0] a, logic isRd, logic [7:0] d, logic rs, logic m2Rise);
    logic win, hi;
    @(negedge clk);
    addr = a; rnw = isRd; data = d; romSelN = rs; m2 = 1'b0;
    @(negedge clk);
    m2 = m2Rise;
    @(negedge clk);
    win = m2Rise && rs && a[14] && a[13];
    hi  = a[12];
    push(K_SEL, {3'b0, !win}, "R1");
    push(K_BRD, {3'b0, !(win && !hi && isRd)}, "R2");
    push(K_BWR, {3'b0, !(win && !hi && !isRd)}, "R2");
    push(K_NRD, {3'b0, !(win && hi && isRd)}, "R2/R8");
    push(K_NWR, {3'b0, !(win && hi && !isRd)}, "R2/R8");
    flush();
    @(negedge clk);
    expectBanks("R9");   // old values while M2 high
    m2 = 1'b0;
    repeat (2) @(negedge clk);
    if (win && !hi && isRd)  mPrg = a[3:0];
    if (win && !hi && !isRd) mChr = d[3:0];
  endtask

  task automatic romCheck(string r);
    @(negedge clk);
    addr = 15'h7FFC; rnw = 1'b1; romSelN = 1'b0; m2 = 1'b1;
    @(negedge clk);
    push(K_FL,  {3'b0, mPrg[3]}, r);
    push(K_RAM, {3'b0, !mPrg[3]}, r);
    push(K_PRG, {2'b0, mPrg[1:0]}, r);
    push(K_SEL, 4'h1, "R1");
    flush();
    m2 = 1'b0; romSelN = 1'b1;
    @(negedge clk);
    push(K_FL, 4'h1, "R6");
    push(K_RAM, 4'h1, "R6");
    flush();
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        expectBanks("R5");
        romCheck("R5");
        // R3: read $6003 loads program bank 3, flash slice 3
        cpuAccess(15'h6003, 1'b1, 8'h00, 1'b1, 1'b1);
        expectBanks("R3");
        romCheck("R7");
        // R4: write $6ABC data 0x5A loads character bank 0xA
        cpuAccess(15'h6ABC, 1'b0, 8'h5A, 1'b1, 1'b1);
        expectBanks("R4");
        // R6: read $6FFC -> bank 12, program RAM slice 0
        cpuAccess(15'h6FFC, 1'b1, 8'h00, 1'b1, 1'b1);
        expectBanks("R6");
        romCheck("R6");
        // R10: middle values latched
        cpuAccess(15'h6006, 1'b1, 8'h00, 1'b1, 1'b1);
        romCheck("R10");
        cpuAccess(15'h6009, 1'b1, 8'h00, 1'b1, 1'b1);
        romCheck("R10");
        // R8: $7xxx accesses leave banks unchanged
        cpuAccess(15'h7123, 1'b0, 8'h03, 1'b1, 1'b1);
        expectBanks("R8");
        cpuAccess(15'h7456, 1'b1, 8'h00, 1'b1, 1'b1);
        expectBanks("R8");
        // R11: unqualified accesses load nothing
        cpuAccess(15'h4005, 1'b1, 8'h00, 1'b1, 1'b1);
        expectBanks("R11");
        cpuAccess(15'h6005, 1'b0, 8'h07, 1'b0, 1'b1);
        expectBanks("R11");
        cpuAccess(15'h6002, 1'b1, 8'h00, 1'b1, 1'b0);
        expectBanks("R11");
        cpuAccess(15'h2001, 1'b0, 8'h0C, 1'b1, 1'b1);
        expectBanks("R11");
        // R4 again with another value, then R5 reset clears both
        cpuAccess(15'h6000, 1'b0, 8'hF3, 1'b1, 1'b1);
        expectBanks("R4");
        cpuAccess(15'h600F, 1'b1, 8'h00, 1'b1, 1'b1);
        romCheck("R3");
        @(negedge clk);
        rstN = 1'b0;
        mPrg = 4'h0; mChr = 4'h0;
        @(negedge clk);
        expectBanks("R5");
        rstN = 1'b1;
        romCheck("R5");
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog actual=timeout expected=finish");
        end
      end
    join_any
    #5;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule